// File: doc/BRIEF.md
# Windowed PS/2 Host Receiver

This block is the host end of a PS/2 keyboard or mouse link, built for a system that polls the device once per video frame. Most of the time it holds the device off by pulling the clock line low and leaving the data line released. The device must then buffer any keystrokes it has. When a frame tick arrives, the block releases the clock and opens a listening window of fixed length. If the device begins a frame inside that window, the block clocks in the data byte, the parity bit and the stop bit on the clock edges the device makes. It then holds the device off again and presents the byte for one cycle.

The window length and the allowed gap between clock edges are given as parameters in system cycles. This lets the block be tuned to any system clock. For example, 880 cycles gives about 110 µs at 8 MHz, which leaves time for a device that waits 50 µs after release before it sends. The data line is never driven, so the block has only one output enable, and it controls the open-drain clock line. Both line inputs go through a synchronizer before any logic uses them.

Top module: `ps2w_rx`

## Requirements
- R1: After reset, `ps2_clk_oe_o` is 1 (clock line pulled low) and `byte_vld_o` and `tmo_o` are 0.
- R2: When a frame or a window ends, `ps2_clk_oe_o` returns to 1 in the same cycle as the `byte_vld_o` or `tmo_o` pulse. It stays 1 until the next frame tick.
- R3: A window opens only on a frame tick. `ps2_clk_oe_o` falls in the cycle after `frame_tick_i` is sampled high while the device is held off. With no tick, the clock line is never released.
- R4: If no start bit is seen, the window lasts exactly `WAIT_CYCLES` cycles with `ps2_clk_oe_o` at 0. The block then pulses `tmo_o` for one cycle and does not pulse `byte_vld_o`.
- R5: After a start bit, the block takes eight data bits, LSB first, on the falling edges of the synchronized clock. The byte appears on `byte_o` with a one-cycle `byte_vld_o` pulse. `byte_o` changes only with that pulse.
- R6: Parity is odd: `par_err_o` is 1 with `byte_vld_o` when the eight data bits and the parity bit together hold an even number of ones. Otherwise it is 0.
- R7: The tenth bit after the start bit is the stop bit. `frm_err_o` is 1 with `byte_vld_o` when the stop bit is 0, and 0 when it is 1.
- R8: If no clock falling edge arrives for `STALL_CYCLES` cycles in the middle of a frame, the frame is dropped. `tmo_o` pulses, no byte is reported, and the device is held off again.
- R9: A start bit is a clock falling edge with data low. A clock falling edge with data high in the window is ignored, and the window runs on to its timeout.
- R10: A frame tick while a frame is being received has no effect. The frame completes normally, and no second window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_tick_i | input | 1 | One-cycle pulse, once per frame, that opens a window |
| ps2_clk_i | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_i | input | 1 | Sensed level of the PS/2 data line |
| ps2_clk_oe_o | output | 1 | 1 = pull the clock line low (device held off) |
| byte_o | output | 8 | Last received data byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| par_err_o | output | 1 | Parity mismatch, qualified by `byte_vld_o` |
| frm_err_o | output | 1 | Stop bit was low, qualified by `byte_vld_o` |
| tmo_o | output | 1 | One-cycle pulse: window or mid-frame timeout |

## Verification
The hardest cases to reach from the ports are those where the line activity disagrees with the state of the block. These are a frame tick that lands in the middle of a frame, a device that stalls partway through a byte, and a clock glitch with data high during a window. The bench drives a model of the device as an open-drain clock that is combined with the block's own pull-down. Each of these cases is brought about with parallel processes: one plays the device frame, and the other fires the tick at a chosen bit. The model can also stop after a few bits or pulse the clock once with data high. The number of window openings and the number of open cycles are counted at the clock output. This shows both the exact window length and that no second window opens.

// File: rtl/ps2w_pkg.sv
package ps2w_pkg;

    localparam int unsigned PS2W_DATA_W = 8;
    // data bits + parity + stop, all taken after the start bit
    localparam int unsigned PS2W_TAIL_W = PS2W_DATA_W + 2;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_LISTEN  = 2'd1,
        ST_RECEIVE = 2'd2
    } ps2w_state_e;

    typedef struct packed {
        logic [PS2W_DATA_W-1:0] data;
        logic                   par_err;
        logic                   frm_err;
    } ps2w_result_t;

    // Split a completed tail (LSB = first data bit) into its fields.
    function automatic ps2w_result_t ps2w_decode(input logic [PS2W_TAIL_W-1:0] tail);
        ps2w_result_t r;
        r.data    = tail[PS2W_DATA_W-1:0];
        r.par_err = ~(^tail[PS2W_DATA_W:0]);
        r.frm_err = ~tail[PS2W_TAIL_W-1];
        return r;
    endfunction

endpackage

// File: rtl/ps2w_sync.sv
module ps2w_sync #(
    parameter int unsigned     WIDTH   = 2,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ps2w_fall_det.sv
module ps2w_fall_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/ps2w_timer.sv
module ps2w_timer #(
    parameter int unsigned LIMIT = 880
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/ps2w_shifter.sv
module ps2w_shifter
    import ps2w_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   clr_i,
    input  logic                   shf_i,
    input  logic                   bit_i,
    output logic [PS2W_TAIL_W-1:0] next_o,
    output logic                   last_o
);
    localparam int unsigned CW = $clog2(PS2W_TAIL_W);
    localparam logic [CW-1:0] LAST = CW'(PS2W_TAIL_W - 1);

    logic [PS2W_TAIL_W-1:0] sh_q;
    logic [CW-1:0]          cnt_q;

    // LSB-first: each new bit enters at the top and moves down
    assign next_o = {bit_i, sh_q[PS2W_TAIL_W-1:1]};
    assign last_o = shf_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shf_i) begin
            sh_q  <= next_o;
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2w_rx.sv
module ps2w_rx
    import ps2w_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES  = 880,
    parameter int unsigned STALL_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   frame_tick_i,
    input  logic                   ps2_clk_i,
    input  logic                   ps2_dat_i,
    output logic                   ps2_clk_oe_o,
    output logic [PS2W_DATA_W-1:0] byte_o,
    output logic                   byte_vld_o,
    output logic                   par_err_o,
    output logic                   frm_err_o,
    output logic                   tmo_o
);
    ps2w_state_e state_q, state_d;

    logic [1:0] line_s;
    logic       clk_s, dat_s, fall;
    logic       lis_exp, stall_exp;
    logic       start_hit, shift_en, frame_last;
    logic [PS2W_TAIL_W-1:0] tail_next;

    ps2w_result_t res_q;
    logic         vld_q, tmo_q;

    // clock line reads low at reset because this block is holding it low
    ps2w_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({ps2_dat_i, ps2_clk_i}),
        .q_o   (line_s)
    );

    assign clk_s = line_s[0];
    assign dat_s = line_s[1];

    ps2w_fall_det u_fall (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (clk_s),
        .fall_o (fall)
    );

    ps2w_timer #(.LIMIT(WAIT_CYCLES)) u_win_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (state_q == ST_LISTEN),
        .clr_i     (1'b0),
        .expired_o (lis_exp)
    );

    ps2w_timer #(.LIMIT(STALL_CYCLES)) u_gap_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (state_q == ST_RECEIVE),
        .clr_i     (fall),
        .expired_o (stall_exp)
    );

    assign start_hit = (state_q == ST_LISTEN) && fall && !dat_s;
    assign shift_en  = (state_q == ST_RECEIVE) && fall;

    ps2w_shifter u_shift (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (start_hit),
        .shf_i  (shift_en),
        .bit_i  (dat_s),
        .next_o (tail_next),
        .last_o (frame_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (frame_tick_i) state_d = ST_LISTEN;
            ST_LISTEN: begin
                if (start_hit)    state_d = ST_RECEIVE;
                else if (lis_exp) state_d = ST_HOLD;
            end
            ST_RECEIVE: begin
                if (frame_last)     state_d = ST_HOLD;
                else if (stall_exp) state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HOLD;
            vld_q   <= 1'b0;
            tmo_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            vld_q   <= frame_last;
            tmo_q   <= ((state_q == ST_LISTEN) && !start_hit && lis_exp)
                    || ((state_q == ST_RECEIVE) && !fall && stall_exp);
            if (frame_last) res_q <= ps2w_decode(tail_next);
        end
    end

    assign ps2_clk_oe_o = (state_q == ST_HOLD);
    assign byte_o       = res_q.data;
    assign par_err_o    = res_q.par_err;
    assign frm_err_o    = res_q.frm_err;
    assign byte_vld_o   = vld_q;
    assign tmo_o        = tmo_q;
endmodule

// File: rtl/ps2w_rx_chk.sv
module ps2w_rx_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       frame_tick_i,
    input logic       ps2_clk_oe_o,
    input logic [7:0] byte_o,
    input logic       byte_vld_o,
    input logic       tmo_o
);
    // R2
    vld_while_held_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_vld_o || tmo_o) |-> ps2_clk_oe_o);

    // R2
    stay_held_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((byte_vld_o || tmo_o) && !frame_tick_i) |=> ps2_clk_oe_o);

    // R3
    open_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ps2_clk_oe_o) |-> $past(frame_tick_i));

    // R4
    tmo_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tmo_o |-> !byte_vld_o);

    // R4
    tmo_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tmo_o |=> !tmo_o);

    // R5
    vld_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_vld_o |=> !byte_vld_o);

    // R5
    byte_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !byte_vld_o |-> $stable(byte_o));
endmodule

bind ps2w_rx ps2w_rx_chk u_ps2w_rx_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .frame_tick_i (frame_tick_i),
    .ps2_clk_oe_o (ps2_clk_oe_o),
    .byte_o       (byte_o),
    .byte_vld_o   (byte_vld_o),
    .tmo_o        (tmo_o)
);

// File: tb/test_ps2w_rx.sv
`timescale 1ns/1ps
module test_ps2w_rx;
    localparam int WAIT_C  = 300;
    localparam int STALL_C = 100;
    localparam int HALF    = 10;
    localparam int NVEC    = 6;

    // entry: {data[7:0], flip parity, stop bit value}
    localparam logic [9:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b1},
        {8'hA5, 1'b0, 1'b1},
        {8'h1C, 1'b1, 1'b1},
        {8'h80, 1'b0, 1'b0},
        {8'h01, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic dev_clk = 1'b1;
    logic dev_dat = 1'b1;
    logic clk_oe;
    logic [7:0] byte_v;
    logic vld, perr, ferr, tmo;
    logic line_clk;

    int checks = 0;
    int fails = 0;
    int n_vld = 0, n_tmo = 0, n_open = 0, n_win = 0;
    logic [7:0] cap_byte = '0;
    logic cap_perr = 1'b0, cap_ferr = 1'b0;
    logic prev_oe = 1'b1;

    always #2 clk = ~clk;

    assign line_clk = clk_oe ? 1'b0 : dev_clk;

    ps2w_rx #(.WAIT_CYCLES(WAIT_C), .STALL_CYCLES(STALL_C)) i_ps2w_rx (
        .clk_i        (clk),
        .rst_i        (rst),
        .frame_tick_i (tick),
        .ps2_clk_i    (line_clk),
        .ps2_dat_i    (dev_dat),
        .ps2_clk_oe_o (clk_oe),
        .byte_o       (byte_v),
        .byte_vld_o   (vld),
        .par_err_o    (perr),
        .frm_err_o    (ferr),
        .tmo_o        (tmo)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (vld) begin
                n_vld++;
                cap_byte = byte_v;
                cap_perr = perr;
                cap_ferr = ferr;
            end
            if (tmo) n_tmo++;
            if (!clk_oe) n_open++;
            if (prev_oe && !clk_oe) n_win++;
            prev_oe = clk_oe;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_vld = 0; n_tmo = 0; n_open = 0; n_win = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic wait_release();
        while (clk_oe) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        dev_dat = b;
        cyc(HALF);
        dev_clk = 1'b0;
        cyc(HALF);
        dev_clk = 1'b1;
    endtask

    // device plays start bit then up to nbits of the 10-bit tail
    task automatic send_frame(input logic [7:0] d, input logic flip, input logic stopv, input int nbits);
        logic [9:0] tail;
        tail = {stopv, (~^d) ^ flip, d};
        wait_release();
        cyc(40);
        send_bit(1'b0);
        for (int i = 0; i < nbits; i++) send_bit(tail[i]);
        dev_dat = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 clk_oe", clk_oe, 1);
        chk("R1 vld", vld, 0);
        chk("R1 tmo", tmo, 0);

        // R3 no tick: line never released even when device wants to talk
        clear_counts();
        dev_dat = 1'b0;
        cyc(400);
        dev_dat = 1'b1;
        chk("R3 no window without tick", n_win, 0);
        chk("R3 no byte without tick", n_vld, 0);

        // R5 R6 R7 table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d;
            d = VEC[v][9:2];
            clear_counts();
            pulse_tick();
            chk("R3 clk_oe falls after tick", clk_oe, 0);
            send_frame(d, VEC[v][1], VEC[v][0], 10);
            cyc(30);
            chk("R5 one byte", n_vld, 1);
            chk("R5 byte LSB first", cap_byte, d);
            chk("R6 parity flag", cap_perr, VEC[v][1]);
            chk("R7 framing flag", cap_ferr, !VEC[v][0]);
            chk("R2 held after frame", clk_oe, 1);
            chk("R4 no timeout on good frame", n_tmo, 0);
            cyc(100);
            chk("R2 stays held", n_win, 1);
            chk("R5 byte kept", byte_v, d);
        end

        // R4 empty window: exact length, one timeout, no byte
        clear_counts();
        pulse_tick();
        cyc(WAIT_C + 50);
        chk("R4 window length", n_open, WAIT_C);
        chk("R4 timeout pulses", n_tmo, 1);
        chk("R4 no byte", n_vld, 0);
        chk("R2 held after timeout", clk_oe, 1);

        // R9 clock fall with data high is not a start
        clear_counts();
        pulse_tick();
        wait_release();
        cyc(20);
        dev_dat = 1'b1;
        dev_clk = 1'b0;
        cyc(HALF);
        dev_clk = 1'b1;
        cyc(WAIT_C + 50);
        chk("R9 no byte from data-high edge", n_vld, 0);
        chk("R9 window timed out", n_tmo, 1);

        // R8 device stalls after three data bits
        clear_counts();
        pulse_tick();
        send_frame(8'h5A, 1'b0, 1'b1, 3);
        cyc(STALL_C + 60);
        chk("R8 stall timeout", n_tmo, 1);
        chk("R8 no byte", n_vld, 0);
        chk("R8 held after stall", clk_oe, 1);

        // R10 tick in mid-frame is ignored
        clear_counts();
        pulse_tick();
        fork
            send_frame(8'h3C, 1'b0, 1'b1, 10);
            begin cyc(120); pulse_tick(); end
        join
        cyc(30);
        chk("R10 one byte", n_vld, 1);
        chk("R10 byte intact", cap_byte, 8'h3C);
        chk("R10 single window", n_win, 1);
        chk("R10 no timeout", n_tmo, 0);
        cyc(WAIT_C + 50);
        chk("R10 no later window", n_win, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule